// File: doc/BRIEF.md
# Event Interrupt Controller with Endpoint Suspend Tracking

This block gathers up to 32 single-cycle event pulses from a packet accelerator into a sticky pending register and drives one level-sensitive interrupt line. Each source has an enable bit and a write-one-to-clear acknowledge bit, and these bits act on that source alone. Software reaches every register through a plain word-addressed read/write port. Reads return their data one cycle after the request.

One source, at index `SUSP_IDX`, reports that a suspended endpoint needs a wakeup. A separate bitmap with one bit per endpoint records which endpoints raised this event. In the normal variant, a per-endpoint enable register chooses which endpoints may set that bitmap, and a per-endpoint clear register removes bitmap bits. When software acknowledges the suspend source in the main clear register, the whole bitmap is wiped. With `LEGACY=1`, every endpoint is always allowed to raise the event, the per-endpoint enable register does not exist, and the per-endpoint clear register does nothing. In that variant the bitmap empties only through the main acknowledge.

None of the pins carries streamed data: event, request and interrupt pins are plain level or pulse controls, and the register port has a fixed one-cycle read latency, so no valid/ready handshake or back-pressure applies.

Top module: `pkt_irq_ctrl`

## Requirements
- R1: After reset, the enable, pending, endpoint-enable and endpoint-bitmap registers are zero, `irq_o` is low and `reg_rdata` is zero.
- R2: A one-cycle pulse on `evt_pulse[i]` sets pending bit i, whatever its enable bit holds. Reading word 1 after the next clock edge returns that bit.
- R3: `irq_o` is high exactly while at least one pending bit has its enable bit set. The enable register is word 0, read/write, bit i for source i. The line falls once the last enabled pending bit is acknowledged or disabled.
- R4: A write to word 2 (acknowledge) clears exactly the pending bits written as one and leaves every other pending bit unchanged.
- R5: If an event pulse and an acknowledge of the same bit occur in the same cycle, the bit stays set. The same rule holds for an endpoint request and a clear of its bitmap bit.
- R6: With LEGACY=0, a pulse on `ep_suspend_req[e]` sets endpoint bitmap bit e (word 4) and pending bit SUSP_IDX (default 4), but only when bit e of the endpoint-enable register (word 3, read/write) is set. Requests from disabled endpoints change nothing.
- R7: With LEGACY=0, a write to word 5 clears exactly the endpoint bitmap bits written as one. The pending bit SUSP_IDX is not changed by this write.
- R8: Acknowledging pending bit SUSP_IDX through word 2 also clears the whole endpoint bitmap.
- R9: With LEGACY=1, every endpoint request sets its bitmap bit and pending bit SUSP_IDX. Word 3 reads zero and ignores writes. Writes to word 5 leave the bitmap unchanged.
- R10: Words 2 and 5 are write-only and read zero. Words 6 and 7 are unmapped and read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe; data appears one cycle later |
| reg_addr | input | 3 | Word offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, held until the next read |
| evt_pulse | input | NUM_EVT | Event pulses, one per source |
| ep_suspend_req | input | NUM_EP | Endpoint suspend request pulses |
| irq_o | output | 1 | Level interrupt |

## Verification
A corrupted pending bit is visible at `irq_o` in the same cycle, as long as that source is enabled. It is also visible on a read of word 1 one cycle after the read request. A wrong endpoint-bitmap bit reaches the ports only through a read of word 4 or through pending bit SUSP_IDX. A bitmap that fails to wipe can therefore stay hidden until software acknowledges the suspend source and reads word 4 again. For that reason the sweeps read the bitmap both before and after every acknowledge.

// File: rtl/pkt_irq_pkg.sv
package pkt_irq_pkg;

  localparam int REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    RA_ENABLE    = 3'd0,
    RA_STATUS    = 3'd1,
    RA_CLEAR     = 3'd2,
    RA_SUSP_EN   = 3'd3,
    RA_SUSP_INFO = 3'd4,
    RA_SUSP_CLR  = 3'd5
  } reg_addr_e;

  typedef struct packed {
    logic en_wr;
    logic clr_wr;
    logic sen_wr;
    logic sclr_wr;
  } wr_strobe_t;

endpackage

// File: rtl/pkt_irq_regif.sv
module pkt_irq_regif
  import pkt_irq_pkg::*;
#(
  parameter int DW      = 32,
  parameter int NUM_EVT = 32,
  parameter int NUM_EP  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr_en,
  input  logic               reg_rd_en,
  input  logic [REG_AW-1:0]  reg_addr,
  input  logic [DW-1:0]      reg_wdata,
  input  logic [NUM_EVT-1:0] status_q,
  input  logic [NUM_EP-1:0]  info_q,
  input  logic [NUM_EP-1:0]  sen_q,
  output logic [NUM_EVT-1:0] enable_q,
  output wr_strobe_t         strobe,
  output logic [DW-1:0]      reg_rdata
);

  logic [DW-1:0] rd_d;

  always_comb begin
    strobe = '0;
    if (reg_wr_en) begin
      case (reg_addr)
        RA_ENABLE:   strobe.en_wr   = 1'b1;
        RA_CLEAR:    strobe.clr_wr  = 1'b1;
        RA_SUSP_EN:  strobe.sen_wr  = 1'b1;
        RA_SUSP_CLR: strobe.sclr_wr = 1'b1;
        default:     strobe = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q <= '0;
    end else if (strobe.en_wr) begin
      enable_q <= reg_wdata[NUM_EVT-1:0];
    end
  end

  always_comb begin
    rd_d = '0;
    case (reg_addr)
      RA_ENABLE:    rd_d[NUM_EVT-1:0] = enable_q;
      RA_STATUS:    rd_d[NUM_EVT-1:0] = status_q;
      RA_SUSP_EN:   rd_d[NUM_EP-1:0]  = sen_q;
      RA_SUSP_INFO: rd_d[NUM_EP-1:0]  = info_q;
      default:      rd_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata <= '0;
    end else if (reg_rd_en) begin
      reg_rdata <= rd_d;
    end
  end

endmodule

// File: rtl/pkt_irq_status.sv
module pkt_irq_status #(
  parameter int NUM_EVT  = 32,
  parameter int SUSP_IDX = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_pulse,
  input  logic               susp_hit,
  input  logic               clr_wr,
  input  logic [NUM_EVT-1:0] clr_mask,
  output logic [NUM_EVT-1:0] status_q,
  output logic               susp_wipe
);

  logic [NUM_EVT-1:0] set_v;
  logic [NUM_EVT-1:0] clr_v;

  assign clr_v     = clr_wr ? clr_mask : '0;
  assign susp_wipe = clr_v[SUSP_IDX];

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_bit
    if (i == SUSP_IDX) begin : g_susp
      assign set_v[i] = evt_pulse[i] | susp_hit;
    end else begin : g_plain
      assign set_v[i] = evt_pulse[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        status_q[i] <= 1'b0;
      end else begin
        status_q[i] <= set_v[i] | (status_q[i] & ~clr_v[i]);
      end
    end
  end

endmodule

// File: rtl/pkt_irq_susp.sv
module pkt_irq_susp #(
  parameter int NUM_EP = 16,
  parameter bit LEGACY = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EP-1:0] ep_suspend_req,
  input  logic              sen_wr,
  input  logic              sclr_wr,
  input  logic [NUM_EP-1:0] wdata,
  input  logic              wipe,
  output logic [NUM_EP-1:0] info_q,
  output logic [NUM_EP-1:0] sen_q,
  output logic              susp_hit
);

  logic [NUM_EP-1:0] allow;
  logic [NUM_EP-1:0] gated;
  logic [NUM_EP-1:0] clr_v;

  if (LEGACY) begin : g_legacy
    assign sen_q = '0;
    assign allow = '1;
    assign clr_v = wipe ? '1 : '0;
  end else begin : g_gated
    logic [NUM_EP-1:0] sen_r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sen_r <= '0;
      end else if (sen_wr) begin
        sen_r <= wdata;
      end
    end
    assign sen_q = sen_r;
    assign allow = sen_r;
    assign clr_v = (wipe ? '1 : '0) | (sclr_wr ? wdata : '0);
  end

  assign gated    = ep_suspend_req & allow;
  assign susp_hit = |gated;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      info_q <= '0;
    end else begin
      info_q <= gated | (info_q & ~clr_v);
    end
  end

endmodule

// File: rtl/pkt_irq_ctrl.sv
module pkt_irq_ctrl
  import pkt_irq_pkg::*;
#(
  parameter int NUM_EVT  = 32,
  parameter int NUM_EP   = 16,
  parameter int SUSP_IDX = 4,
  parameter bit LEGACY   = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr_en,
  input  logic               reg_rd_en,
  input  logic [2:0]         reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic [NUM_EVT-1:0] evt_pulse,
  input  logic [NUM_EP-1:0]  ep_suspend_req,
  output logic               irq_o
);

  localparam int DW = 32;

  logic [NUM_EVT-1:0] status_q;
  logic [NUM_EVT-1:0] enable_q;
  logic [NUM_EP-1:0]  info_q;
  logic [NUM_EP-1:0]  sen_q;
  logic               susp_hit;
  logic               susp_wipe;
  wr_strobe_t         strobe;

  pkt_irq_regif #(.DW(DW), .NUM_EVT(NUM_EVT), .NUM_EP(NUM_EP)) u_regif (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr_en (reg_wr_en),
    .reg_rd_en (reg_rd_en),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .status_q  (status_q),
    .info_q    (info_q),
    .sen_q     (sen_q),
    .enable_q  (enable_q),
    .strobe    (strobe),
    .reg_rdata (reg_rdata)
  );

  pkt_irq_status #(.NUM_EVT(NUM_EVT), .SUSP_IDX(SUSP_IDX)) u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_pulse (evt_pulse),
    .susp_hit  (susp_hit),
    .clr_wr    (strobe.clr_wr),
    .clr_mask  (reg_wdata[NUM_EVT-1:0]),
    .status_q  (status_q),
    .susp_wipe (susp_wipe)
  );

  pkt_irq_susp #(.NUM_EP(NUM_EP), .LEGACY(LEGACY)) u_susp (
    .clk            (clk),
    .rst_n          (rst_n),
    .ep_suspend_req (ep_suspend_req),
    .sen_wr         (strobe.sen_wr),
    .sclr_wr        (strobe.sclr_wr),
    .wdata          (reg_wdata[NUM_EP-1:0]),
    .wipe           (susp_wipe),
    .info_q         (info_q),
    .sen_q          (sen_q),
    .susp_hit       (susp_hit)
  );

  assign irq_o = |(status_q & enable_q);

endmodule

// File: rtl/pkt_irq_ctrl_chk.sv
module pkt_irq_ctrl_chk
  import pkt_irq_pkg::*;
#(
  parameter int NUM_EVT  = 32,
  parameter int NUM_EP   = 16,
  parameter int SUSP_IDX = 4,
  parameter bit LEGACY   = 1'b0
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_wr_en,
  input logic               reg_rd_en,
  input logic [2:0]         reg_addr,
  input logic [31:0]        reg_wdata,
  input logic [31:0]        reg_rdata,
  input logic [NUM_EVT-1:0] evt_pulse,
  input logic [NUM_EP-1:0]  ep_suspend_req,
  input logic               irq_o,
  input logic [NUM_EVT-1:0] status_q,
  input logic [NUM_EP-1:0]  info_q,
  input logic [NUM_EP-1:0]  sen_q
);

  logic [NUM_EVT-1:0] ack_mask;
  logic [NUM_EP-1:0]  info_drop_ok;
  logic               wr_clr;
  logic               wr_sclr;

  assign wr_clr   = reg_wr_en && (reg_addr == RA_CLEAR);
  assign wr_sclr  = reg_wr_en && (reg_addr == RA_SUSP_CLR);
  assign ack_mask = wr_clr ? reg_wdata[NUM_EVT-1:0] : '0;

  always_comb begin
    info_drop_ok = '0;
    if (wr_clr && reg_wdata[SUSP_IDX]) info_drop_ok = '1;
    if (!LEGACY && wr_sclr) info_drop_ok = info_drop_ok | reg_wdata[NUM_EP-1:0];
  end

  AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_pulse != '0) |=> ((status_q & $past(evt_pulse)) == $past(evt_pulse))); // R5

  AST_ACK_ONLY_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(status_q) & ~status_q) & ~$past(ack_mask)) == '0)); // R4

  AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> ($past(evt_pulse) != '0 || $past(ep_suspend_req) != '0 || $past(reg_wr_en))); // R3

  AST_IRQ_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_o) |-> $past(reg_wr_en)); // R3

  AST_INFO_WIPE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && reg_wdata[SUSP_IDX] && ep_suspend_req == '0) |=> (info_q == '0)); // R8

  AST_INFO_DROP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(info_q) & ~info_q) & ~$past(info_drop_ok)) == '0)); // R9

  AST_WO_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_en && (reg_addr == RA_CLEAR || reg_addr == RA_SUSP_CLR)) |=> (reg_rdata == '0)); // R10

  if (!LEGACY) begin : g_gate_chk
    AST_SUSP_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (((info_q & ~$past(info_q)) & ~$past(sen_q)) == '0)); // R6
  end else begin : g_legacy_chk
    AST_LEGACY_NO_SEN: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |-> (sen_q == '0)); // R9
  end

endmodule

bind pkt_irq_ctrl pkt_irq_ctrl_chk #(
  .NUM_EVT(NUM_EVT), .NUM_EP(NUM_EP), .SUSP_IDX(SUSP_IDX), .LEGACY(LEGACY)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .reg_wr_en      (reg_wr_en),
  .reg_rd_en      (reg_rd_en),
  .reg_addr       (reg_addr),
  .reg_wdata      (reg_wdata),
  .reg_rdata      (reg_rdata),
  .evt_pulse      (evt_pulse),
  .ep_suspend_req (ep_suspend_req),
  .irq_o          (irq_o),
  .status_q       (status_q),
  .info_q         (info_q),
  .sen_q          (sen_q)
);

// File: tb/pkt_irq_ctrl_tb.sv
module pkt_irq_ctrl_tb;

  localparam int NEVT = 32;
  localparam int NEP  = 8;
  localparam int SIDX = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            reg_wr_en = 1'b0;
  logic            reg_rd_en = 1'b0;
  logic [2:0]      reg_addr = '0;
  logic [31:0]     reg_wdata = '0;
  logic [NEVT-1:0] evt_pulse = '0;
  logic [NEP-1:0]  ep_req = '0;
  logic [31:0]     rdata_n, rdata_l;
  logic            irq_n, irq_l;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  pkt_irq_ctrl #(.NUM_EVT(NEVT), .NUM_EP(NEP), .SUSP_IDX(SIDX), .LEGACY(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rdata_n),
    .evt_pulse(evt_pulse), .ep_suspend_req(ep_req), .irq_o(irq_n)
  );

  pkt_irq_ctrl #(.NUM_EVT(NEVT), .NUM_EP(NEP), .SUSP_IDX(SIDX), .LEGACY(1'b1)) u_dut_legacy (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rdata_l),
    .evt_pulse(evt_pulse), .ep_suspend_req(ep_req), .irq_o(irq_l)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] dn, output logic [31:0] dl);
    reg_rd_en = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd_en = 1'b0;
    dn = rdata_n; dl = rdata_l;
  endtask

  task automatic pulse_evt(input logic [NEVT-1:0] m);
    evt_pulse = m; @(negedge clk); evt_pulse = '0;
  endtask

  task automatic pulse_ep(input logic [NEP-1:0] m);
    ep_req = m; @(negedge clk); ep_req = '0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] vn, vl, en_m, exp_st;
    repeat (3) @(negedge clk);
    // R1 / R10: reset values and read map
    check("R1 irq", {30'd0, irq_n, irq_l}, 32'd0);
    check("R1 rdata", rdata_n | rdata_l, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), vn, vl);
      check("R1 R10 reset read", vn | vl, 32'd0);
    end

    // R2 / R3: walk each source, enable on odd indices
    for (int i = 0; i < NEVT; i++) begin
      en_m = (i % 2 == 1) ? (32'd1 << i) : 32'd0;
      wr(3'd0, en_m);
      rd(3'd0, vn, vl);
      check("R3 enable readback", vn, en_m);
      pulse_evt(NEVT'(32'd1 << i));
      rd(3'd1, vn, vl);
      check("R2 pending set", vn, 32'd1 << i);
      check("R3 irq level", {31'd0, irq_n}, (i % 2 == 1) ? 32'd1 : 32'd0);
      wr(3'd2, 32'd1 << i);
      rd(3'd1, vn, vl);
      check("R4 pending cleared", vn, 32'd0);
      check("R3 irq falls", {31'd0, irq_n}, 32'd0);
    end

    // R4: partial acknowledge patterns
    for (int p = 0; p < 4; p++) begin
      logic [31:0] msk;
      msk = 32'h0F0F_00FF ^ (32'h1357_9BDF << p);
      pulse_evt('1);
      wr(3'd2, msk);
      rd(3'd1, vn, vl);
      check("R4 partial ack", vn, ~msk);
      wr(3'd2, 32'hFFFF_FFFF);
    end

    // R5: set wins over same-cycle acknowledge
    pulse_evt(NEVT'(32'h0000_0100));
    evt_pulse = NEVT'(32'h0000_0080);
    wr(3'd2, 32'h0000_0180);
    evt_pulse = '0;
    rd(3'd1, vn, vl);
    check("R5 set over ack", vn, 32'h0000_0080);
    wr(3'd2, 32'hFFFF_FFFF);

    // R6 / R9 / R8: sweep all endpoint-enable masks
    for (int m = 0; m < (1 << NEP); m++) begin
      wr(3'd3, 32'(m));
      rd(3'd3, vn, vl);
      check("R6 endpoint enable readback", vn, 32'(m));
      check("R9 legacy enable reads zero", vl, 32'd0);
      pulse_ep('1);
      rd(3'd4, vn, vl);
      check("R6 bitmap gated", vn, 32'(m));
      check("R9 bitmap ungated", vl, 32'h0000_00FF);
      rd(3'd1, vn, vl);
      exp_st = (m != 0) ? (32'd1 << SIDX) : 32'd0;
      check("R6 suspend pending", vn, exp_st);
      check("R9 legacy suspend pending", vl, 32'd1 << SIDX);
      wr(3'd2, 32'd1 << SIDX);
      rd(3'd4, vn, vl);
      check("R8 wipe on ack", vn | vl, 32'd0);
    end

    // R7 / R9: per-endpoint clear
    wr(3'd3, 32'h0000_00FF);
    pulse_ep('1);
    wr(3'd5, 32'h0000_000F);
    rd(3'd4, vn, vl);
    check("R7 endpoint clear", vn, 32'h0000_00F0);
    check("R9 legacy clear ignored", vl, 32'h0000_00FF);
    rd(3'd1, vn, vl);
    check("R7 pending kept", vn, 32'd1 << SIDX);
    rd(3'd5, vn, vl);
    check("R10 endpoint clear reads zero", vn | vl, 32'd0);
    rd(3'd2, vn, vl);
    check("R10 ack reads zero", vn | vl, 32'd0);

    // R3: suspend source drives irq when enabled
    wr(3'd0, 32'd1 << SIDX);
    check("R3 irq from suspend", {30'd0, irq_n, irq_l}, 32'd3);

    // R5: endpoint request wins over same-cycle endpoint clear
    ep_req = NEP'(8'h01);
    wr(3'd5, 32'h0000_0001);
    ep_req = '0;
    rd(3'd4, vn, vl);
    check("R5 request over clear", vn, 32'h0000_00F1);

    // R8 with request in the same cycle: request survives the wipe
    ep_req = NEP'(8'h02);
    wr(3'd2, 32'd1 << SIDX);
    ep_req = '0;
    rd(3'd4, vn, vl);
    check("R8 wipe keeps new request", vn, 32'h0000_0002);
    check("R8 legacy wipe keeps new request", vl, 32'h0000_0002);
    wr(3'd2, 32'd1 << SIDX);
    rd(3'd4, vn, vl);
    check("R8 final wipe", vn | vl, 32'd0);
    check("R3 irq low after wipe", {30'd0, irq_n, irq_l}, 32'd0);

    finish_run();
  end

endmodule